// File: doc/BRIEF.md
# SIMD Floating-Point Control Register Load Checker

This block holds the 32-bit control/status word that governs SIMD floating-point arithmetic, and it judges every load request before letting the new word in. A load request carries a 32-bit data word and a short decoded-instruction descriptor. The descriptor has an encoding-form flag that selects the legacy form or the vector-extended form. It also has a vector-length bit and a 4-bit register-specifier field, and these two count only in the vector-extended form. The block gives back the stored word, a one-cycle invalid-opcode fault pulse, a one-cycle general-protection fault pulse and a sticky pending-exception indication.

The checks run in a fixed order. A bad encoding is found first. Only when the encoding is clean does a nonzero reserved field raise a general-protection fault. A load that passes both checks replaces the word. The block does not signal at once a load that unmasks an exception whose flag is already set. It raises a pending indication instead, which a later SIMD floating-point instruction consumes through a take input. No processor-mode input exists, because the outcome is the same in every mode.

Field layout of the word:

| Bits | Meaning |
|---|---|
| 5:0 | sticky exception flags |
| 6 | treat denormal inputs as zero |
| 12:7 | exception masks; bit 7+k masks flag k |
| 14:13 | rounding control |
| 15 | flush results to zero |
| 31:16 | reserved, must be zero |

Top module: `fpcsr_load_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no load, the register reads 32'h00001F80, both fault outputs are 0 and the pending output is 0.
- R2: A load that passes every check writes the whole 32-bit data word unchanged. The new value shows on the register output after the clock edge that samples the request.
- R3: In the vector-extended form (form flag = 1), a load whose vector-length bit is 1 pulses the invalid-opcode fault in the cycle after the sampling edge and leaves the register unchanged.
- R4: In the vector-extended form, a load whose register-specifier field is not 4'b1111 pulses the invalid-opcode fault and leaves the register unchanged.
- R5: A load that passes the encoding checks but has any of bits 31:16 set pulses the general-protection fault in the cycle after the sampling edge and leaves the register unchanged.
- R6: An encoding fault takes priority over a reserved-bit fault. At most one fault output is high in any cycle, and each fault pulse lasts a single cycle.
- R7: After a successful load, the pending output equals the OR over k = 0..5 of (data bit k AND NOT data bit 7+k). No fault is raised for this condition.
- R8: The take input clears the pending output at the next edge, unless a successful load is sampled at that edge, in which case the value from R7 wins. A faulting load does not change the pending output.
- R9: In the legacy form (form flag = 0), the vector-length bit and the register-specifier field have no effect on the result.
- R10: In a cycle with no load request, the register holds its value and neither fault output pulses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load request strobe |
| ld_data | input | 32 | Data word to load |
| ld_vex | input | 1 | Encoding form: 0 legacy, 1 vector-extended |
| ld_len | input | 1 | Vector-length bit of the descriptor |
| ld_spec | input | 4 | Register-specifier field of the descriptor |
| pend_take | input | 1 | Consumes the pending exception |
| csr_q | output | 32 | Current register contents |
| fault_ud | output | 1 | Invalid-opcode fault pulse |
| fault_gp | output | 1 | General-protection fault pulse |
| pend_exc | output | 1 | Pending deferred-exception indication |

## Verification
Every result comes from a single register stage. The register contents, both fault pulses and the pending indication all change at the edge that samples the request, so each is due exactly one cycle after the stimulus is applied. The bench drives each request on a falling edge and computes the expected state for the next rising edge from its own model. It compares all four outputs on the following falling edge, one clock after the stimulus and before the next one is applied. Idle cycles are compared the same way, which shows that fault pulses last one cycle and that the register holds its value.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  localparam int CSR_W    = 32;
  localparam int N_EXC    = 6;
  localparam int FLAG_LSB = 0;
  localparam int MASK_LSB = 7;
  localparam int RSV_LSB  = 16;
  localparam int SPEC_W   = 4;

  localparam logic [CSR_W-1:0] CSR_RESET = 32'h0000_1F80;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } fault_e;

  // An exception is exposed when its flag is set and its mask is clear.
  function automatic logic [N_EXC-1:0] exposed_vec(input logic [N_EXC-1:0] flags,
                                                   input logic [N_EXC-1:0] masks);
    return flags & ~masks;
  endfunction

endpackage

// File: rtl/fpcsr_enc_check.sv
module fpcsr_enc_check
  import fpcsr_pkg::*;
#(
  parameter int SPEC_BITS = SPEC_W,
  parameter int RSV_BITS  = CSR_W - RSV_LSB
) (
  input  logic                 ld_valid,
  input  logic                 ld_vex,
  input  logic                 ld_len,
  input  logic [SPEC_BITS-1:0] ld_spec,
  input  logic [RSV_BITS-1:0]  rsv_field,
  output logic                 enc_bad,
  output logic                 rsv_bad,
  output logic                 load_ok,
  output fault_e               verdict
);

  localparam logic [SPEC_BITS-1:0] SPEC_REQUIRED = '1;

  // The encoding check comes first; the reserved check runs only on a clean encoding.
  assign enc_bad = ld_valid && ld_vex && (ld_len || (ld_spec != SPEC_REQUIRED));
  assign rsv_bad = ld_valid && !enc_bad && (|rsv_field);
  assign load_ok = ld_valid && !enc_bad && !rsv_bad;

  always_comb begin
    if (enc_bad)      verdict = FLT_UD;
    else if (rsv_bad) verdict = FLT_GP;
    else              verdict = FLT_NONE;
  end

endmodule

// File: rtl/fpcsr_word_reg.sv
module fpcsr_word_reg
  import fpcsr_pkg::*;
#(
  parameter int               WIDTH     = CSR_W,
  parameter logic [WIDTH-1:0] RESET_VAL = CSR_RESET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] word_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= RESET_VAL;
    else if (wr_en) word_q <= wr_data;
  end

endmodule

// File: rtl/fpcsr_pending.sv
module fpcsr_pending
  import fpcsr_pkg::*;
#(
  parameter int NEXC = N_EXC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_ok,
  input  logic [NEXC-1:0] new_flags,
  input  logic [NEXC-1:0] new_masks,
  input  logic            take,
  output logic            pend_q
);

  logic [NEXC-1:0] exposed;
  logic [NEXC-1:0] exposed_fn;
  logic            any_exposed;

  assign exposed_fn = exposed_vec(new_flags, new_masks);

  // One flag/mask pair per exception position.
  for (genvar k = 0; k < NEXC; k++) begin : g_pos
    assign exposed[k] = exposed_fn[k];
  end

  assign any_exposed = |exposed;

  // A successful load overrides the take input in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (load_ok) pend_q <= any_exposed;
    else if (take)    pend_q <= 1'b0;
  end

endmodule

// File: rtl/fpcsr_load_unit.sv
module fpcsr_load_unit
  import fpcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [CSR_W-1:0] ld_data,
  input  logic             ld_vex,
  input  logic             ld_len,
  input  logic [SPEC_W-1:0] ld_spec,
  input  logic             pend_take,
  output logic [CSR_W-1:0] csr_q,
  output logic             fault_ud,
  output logic             fault_gp,
  output logic             pend_exc
);

  localparam int RSV_BITS = CSR_W - RSV_LSB;

  // Internal events, brought out for the checker.
  logic   enc_bad;
  logic   rsv_bad;
  logic   load_ok;
  fault_e verdict;

  fpcsr_enc_check #(
    .SPEC_BITS (SPEC_W),
    .RSV_BITS  (RSV_BITS)
  ) i_check (
    .ld_valid  (ld_valid),
    .ld_vex    (ld_vex),
    .ld_len    (ld_len),
    .ld_spec   (ld_spec),
    .rsv_field (ld_data[CSR_W-1:RSV_LSB]),
    .enc_bad   (enc_bad),
    .rsv_bad   (rsv_bad),
    .load_ok   (load_ok),
    .verdict   (verdict)
  );

  fpcsr_word_reg #(
    .WIDTH     (CSR_W),
    .RESET_VAL (CSR_RESET)
  ) i_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (load_ok),
    .wr_data (ld_data),
    .word_q  (csr_q)
  );

  fpcsr_pending #(
    .NEXC (N_EXC)
  ) i_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ok   (load_ok),
    .new_flags (ld_data[FLAG_LSB +: N_EXC]),
    .new_masks (ld_data[MASK_LSB +: N_EXC]),
    .take      (pend_take),
    .pend_q    (pend_exc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_ud <= 1'b0;
      fault_gp <= 1'b0;
    end else begin
      fault_ud <= (verdict == FLT_UD);
      fault_gp <= (verdict == FLT_GP);
    end
  end

endmodule

// File: rtl/fpcsr_load_chk.sv
module fpcsr_load_chk
  import fpcsr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic [CSR_W-1:0] ld_data,
  input logic             pend_take,
  input logic [CSR_W-1:0] csr_q,
  input logic             fault_ud,
  input logic             fault_gp,
  input logic             pend_exc,
  input logic             enc_bad,
  input logic             load_ok
);

  p_one_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_ud && fault_gp));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> (!fault_ud && !fault_gp));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> $stable(csr_q));

  p_copy_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (csr_q == $past(ld_data)));

  p_ud_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ud |-> $stable(csr_q));

  p_enc_to_ud_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enc_bad |=> fault_ud);

  p_gp_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_gp |-> $stable(csr_q));

  p_pend_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (pend_exc ==
      (|($past(ld_data[FLAG_LSB +: N_EXC]) & ~$past(ld_data[MASK_LSB +: N_EXC])))));

  p_take_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_take && !load_ok) |=> !pend_exc);

endmodule

bind fpcsr_load_unit fpcsr_load_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .ld_data   (ld_data),
  .pend_take (pend_take),
  .csr_q     (csr_q),
  .fault_ud  (fault_ud),
  .fault_gp  (fault_gp),
  .pend_exc  (pend_exc),
  .enc_bad   (enc_bad),
  .load_ok   (load_ok)
);

// File: tb/test_fpcsr_load_unit.sv
module test_fpcsr_load_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_data = '0;
  logic        ld_vex = 1'b0;
  logic        ld_len = 1'b0;
  logic [3:0]  ld_spec = '0;
  logic        pend_take = 1'b0;
  logic [31:0] csr_q;
  logic        fault_ud;
  logic        fault_gp;
  logic        pend_exc;

  int n_checks = 0;
  int n_fails  = 0;

  // Reference state
  logic [31:0] m_csr  = 32'h0000_1F80;
  logic        m_ud   = 1'b0;
  logic        m_gp   = 1'b0;
  logic        m_pend = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fpcsr_load_unit i_fpcsr_load_unit (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_vex(ld_vex), .ld_len(ld_len), .ld_spec(ld_spec), .pend_take(pend_take),
    .csr_q(csr_q), .fault_ud(fault_ud), .fault_gp(fault_gp), .pend_exc(pend_exc)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "csr_q",    csr_q,            m_csr);
    check(tag, "fault_ud", {31'd0, fault_ud}, {31'd0, m_ud});
    check(tag, "fault_gp", {31'd0, fault_gp}, {31'd0, m_gp});
    check(tag, "pend_exc", {31'd0, pend_exc}, {31'd0, m_pend});
  endtask

  // Applies one cycle of stimulus at a falling edge, predicts, then compares one clock later.
  task automatic cyc(input logic v, input logic [31:0] d, input logic vex,
                     input logic len, input logic [3:0] spec, input logic take,
                     input string tag);
    logic ok;
    logic p;
    ld_valid = v; ld_data = d; ld_vex = vex; ld_len = len; ld_spec = spec;
    pend_take = take;
    m_ud = 1'b0;
    m_gp = 1'b0;
    ok = 1'b0;
    if (v) begin
      if (vex && (len || spec != 4'hF))  m_ud = 1'b1;
      else if ((d >> 16) != 0)           m_gp = 1'b1;
      else begin
        ok = 1'b1;
        m_csr = d;
        p = 1'b0;
        for (int k = 0; k < 6; k++)
          if (d[k] && !d[k + 7]) p = 1'b1;
        m_pend = p;
      end
    end
    if (!ok && take) m_pend = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #2_000_000;
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after reset");

    // R10: idle with noisy inputs
    cyc(1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h0, 1'b0, "R10 idle");

    // R2: plain loads
    cyc(1'b1, 32'h0000_6A80, 1'b0, 1'b0, 4'hF, 1'b0, "R2 legacy load");
    cyc(1'b1, 32'h0000_FFC0, 1'b1, 1'b0, 4'hF, 1'b0, "R2 vex load");
    cyc(1'b0, 32'h0000_0000, 1'b0, 1'b0, 4'h0, 1'b0, "R10 hold");

    // R9: legacy ignores length and specifier
    cyc(1'b1, 32'h0000_1F85, 1'b0, 1'b1, 4'h3, 1'b0, "R9 legacy ignores descriptor");

    // R3 / R4: encoding faults
    cyc(1'b1, 32'h0000_0000, 1'b1, 1'b1, 4'hF, 1'b0, "R3 length bit");
    cyc(1'b0, 32'h0000_0000, 1'b0, 1'b0, 4'h0, 1'b0, "R6 pulse ends");
    cyc(1'b1, 32'h0000_0040, 1'b1, 1'b0, 4'h7, 1'b0, "R4 specifier");
    cyc(1'b1, 32'h0000_0040, 1'b1, 1'b0, 4'hE, 1'b0, "R4 specifier low bit");

    // R5: reserved bits
    cyc(1'b1, 32'h0001_1F80, 1'b0, 1'b0, 4'h0, 1'b0, "R5 bit 16");
    cyc(1'b1, 32'h8000_1F80, 1'b1, 1'b0, 4'hF, 1'b0, "R5 bit 31");

    // R6: encoding beats reserved
    cyc(1'b1, 32'hFFFF_0000, 1'b1, 1'b0, 4'h0, 1'b0, "R6 priority");
    cyc(1'b0, 32'h0000_0000, 1'b0, 1'b0, 4'h0, 1'b0, "R6 pulse ends");

    // R7 / R8: deferred exception
    cyc(1'b1, 32'h0000_1F01, 1'b0, 1'b0, 4'h0, 1'b0, "R7 unmask invalid");
    cyc(1'b1, 32'h0001_0000, 1'b0, 1'b0, 4'h0, 1'b0, "R8 fault keeps pending");
    cyc(1'b0, 32'h0000_0000, 1'b0, 1'b0, 4'h0, 1'b1, "R8 take clears");
    cyc(1'b1, 32'h0000_0FA0, 1'b0, 1'b0, 4'h0, 1'b0, "R7 precision unmasked");
    cyc(1'b1, 32'h0000_1F80, 1'b0, 1'b0, 4'h0, 1'b0, "R7 masked load clears");
    cyc(1'b1, 32'h0000_1E3F, 1'b0, 1'b0, 4'h0, 1'b1, "R8 load beats take");
    cyc(1'b1, 32'h0000_0000, 1'b1, 1'b1, 4'hF, 1'b1, "R8 take with faulting load");

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      d = $urandom & 32'h0000_FFFF;
      if (($urandom % 5) == 0) d = d | (32'h1 << (16 + ($urandom % 16)));
      cyc(($urandom % 4) != 0, d, $urandom % 2, ($urandom % 4) == 0,
          (($urandom % 3) == 0) ? 4'($urandom) : 4'hF, ($urandom % 6) == 0,
          "R2 R7 mixed");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule